// File: doc/BRIEF.md
# Interval Timer Register Access Sequencer

This block is the byte-wide host interface of a multi-channel interval timer. It does not count. A host issues one byte access per cycle on a two-bit address. Addresses below the channel count reach a channel's data port. Address 3 takes control words. For every channel the block holds the operating mode, the byte access mode and the decimal-count flag. It turns byte writes into a one-cycle load strobe that carries a 16-bit initial count. Reads sample the live count and output level that the counting logic supplies.

Two kinds of snapshot can be taken. A counter-latch control word freezes one channel's count. A read-back control word can freeze the count, the status byte, or both, for any set of channels in a single write. A frozen value is held until the host reads it. The status snapshot is always returned before the count snapshot, and the count snapshot before the live value. In word access mode both writes and reads alternate between the low byte and the high byte.

Top module: `tmr_access_seq`

## Requirements
- R1: After reset every channel is in LSB access mode (code 1), mode 0, binary counting, with no latched values. A data read returns the low byte of the live count and does not alternate.
- R2: A control-word write (bus_wdata[7:6] = channel < 3, bus_wdata[5:4] != 0) sets the access mode from bits 5:4 (1 = low byte only, 2 = high byte only, 3 = low then high). It sets the mode from bits 3:1, with 6 and 7 folded to 2 and 3, and the decimal flag from bit 0. It also resets both byte pointers of that channel to the low byte.
- R3: A data write in access mode 1 loads {8'h00, byte}, and in access mode 2 loads {byte, 8'h00}. ld_stb for that channel alone is high for exactly the cycle after the write, and ld_val carries the value.
- R4: In access mode 3 the first data write only holds the byte and gives no strobe. The second write loads {second, first}.
- R5: A control word with bits 5:4 = 00 captures the selected channel's count. Reads then return it as the access mode dictates: in mode 3 the low byte and then the high byte.
- R6: Live reads return the low byte in mode 1 and the high byte in mode 2. In mode 3 they alternate, low first.
- R7: A control word with bits 7:6 = 3 is a read-back. Bits 1, 2 and 3 select channels 0, 1 and 2. Bit 5 = 0 captures the count and bit 4 = 0 captures the status. Unselected channels are untouched.
- R8: The status byte holds OUT in bit 7, zero in bit 6, the access mode in bits 5:4, the mode in bits 3:1 and the decimal flag in bit 0.
- R9: A count capture or status capture request is ignored while an earlier capture of the same kind is still unread.
- R10: A read returns a captured status first, then a captured count, then the live count. Each captured item is consumed by its read.
- R11: A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe (ignored when bus_wr is high) |
| bus_addr | input | 2 | 0..2 channel data, 3 control |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational in the read cycle |
| cnt_in | input | 48 | Live 16-bit count of each channel, channel c at [16c+15:16c] |
| out_in | input | 3 | Live output level of each channel |
| ld_stb | output | 3 | One-cycle load strobe per channel |
| ld_val | output | 48 | Count to load, channel c at [16c+15:16c] |

## Verification
A wrong byte pointer shows on the very next data read, as the wrong half of the count, or on the next write as a missing or early load strobe. A capture that is stuck set or lost shows as a stale or a live value at the first read after the capture command. A bad field from the control decode shows in the status byte when the next read-back is read. The bench sweeps every control-word value for every channel through a status read-back. It then checks pointer order, capture priority and the rule that repeated captures are ignored.

// File: rtl/tmr_acc_pkg.sv
package tmr_acc_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 2 * BYTE_W;

   // access-mode codes; ACC_NONE doubles as "no count captured"
   localparam logic [1:0] ACC_NONE = 2'd0;
   localparam logic [1:0] ACC_LO   = 2'd1;
   localparam logic [1:0] ACC_HI   = 2'd2;
   localparam logic [1:0] ACC_WORD = 2'd3;

   function automatic logic [2:0] fold_mode(input logic [2:0] m);
      return (m > 3'd5) ? (m - 3'd4) : m;
   endfunction
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode #(
   parameter int NUM_CH = 3
) (
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [7:1]        wbits,
   output logic [NUM_CH-1:0] cfg_we,
   output logic [NUM_CH-1:0] cnt_req,
   output logic [NUM_CH-1:0] stat_req,
   output logic [NUM_CH-1:0] data_we,
   output logic [NUM_CH-1:0] data_re
);
   localparam logic [1:0] CTL_ADDR = 2'd3;

   logic ctl_wr, rb_cmd;
   assign ctl_wr = wr_en && (addr == CTL_ADDR);
   assign rb_cmd = ctl_wr && (wbits[7:6] == 2'd3);

   always_comb begin
      for (int i = 0; i < NUM_CH; i++) begin
         data_we[i]  = wr_en && (addr == 2'(i));
         data_re[i]  = rd_en && !wr_en && (addr == 2'(i));
         cfg_we[i]   = 1'b0;
         cnt_req[i]  = 1'b0;
         stat_req[i] = 1'b0;
         if (rb_cmd) begin
            if (wbits[i+1]) begin
               cnt_req[i]  = !wbits[5];
               stat_req[i] = !wbits[4];
            end
         end else if (ctl_wr && (wbits[7:6] == 2'(i))) begin
            if (wbits[5:4] == 2'd0) cnt_req[i] = 1'b1;
            else                    cfg_we[i]  = 1'b1;
         end
      end
   end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
   import tmr_acc_pkg::*;
#(
   parameter logic [1:0] DEF_ACC = ACC_LO
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [5:0]        cfg_bits,
   input  logic              cnt_req,
   input  logic              stat_req,
   input  logic              data_we,
   input  logic              data_re,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [WORD_W-1:0] cnt_live,
   input  logic              out_live,
   output logic [BYTE_W-1:0] rdata,
   output logic              ld_stb,
   output logic [WORD_W-1:0] ld_val
);
   logic [1:0]        acc_q;
   logic [2:0]        mode_q;
   logic              bcd_q;
   logic              wr_hi_q, rd_hi_q;
   logic [BYTE_W-1:0] hold_q;
   logic [1:0]        clat_q;
   logic [WORD_W-1:0] clat_val_q;
   logic              slat_q;
   logic [BYTE_W-1:0] slat_val_q;

   always_comb begin
      if (slat_q)
         rdata = slat_val_q;
      else if (clat_q != ACC_NONE)
         rdata = (clat_q == ACC_HI) ? clat_val_q[WORD_W-1:BYTE_W] : clat_val_q[BYTE_W-1:0];
      else if (acc_q == ACC_HI || (acc_q == ACC_WORD && rd_hi_q))
         rdata = cnt_live[WORD_W-1:BYTE_W];
      else
         rdata = cnt_live[BYTE_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q      <= DEF_ACC;
         mode_q     <= 3'd0;
         bcd_q      <= 1'b0;
         wr_hi_q    <= 1'b0;
         rd_hi_q    <= 1'b0;
         hold_q     <= '0;
         clat_q     <= ACC_NONE;
         clat_val_q <= '0;
         slat_q     <= 1'b0;
         slat_val_q <= '0;
         ld_stb     <= 1'b0;
         ld_val     <= '0;
      end else begin
         ld_stb <= 1'b0;
         if (cfg_we) begin
            acc_q   <= cfg_bits[5:4];
            mode_q  <= fold_mode(cfg_bits[3:1]);
            bcd_q   <= cfg_bits[0];
            wr_hi_q <= 1'b0;
            rd_hi_q <= 1'b0;
         end
         if (cnt_req && clat_q == ACC_NONE) begin
            clat_q     <= acc_q;
            clat_val_q <= cnt_live;
         end
         if (stat_req && !slat_q) begin
            slat_q     <= 1'b1;
            slat_val_q <= {out_live, 1'b0, acc_q, mode_q, bcd_q};
         end
         if (data_we) begin
            case (acc_q)
               ACC_HI: begin
                  ld_stb <= 1'b1;
                  ld_val <= {wdata, {BYTE_W{1'b0}}};
               end
               ACC_WORD: begin
                  if (wr_hi_q) begin
                     ld_stb <= 1'b1;
                     ld_val <= {wdata, hold_q};
                  end else begin
                     hold_q <= wdata;
                  end
                  wr_hi_q <= !wr_hi_q;
               end
               default: begin
                  ld_stb <= 1'b1;
                  ld_val <= {{BYTE_W{1'b0}}, wdata};
               end
            endcase
         end
         if (data_re) begin
            if (slat_q)
               slat_q <= 1'b0;
            else if (clat_q != ACC_NONE)
               clat_q <= (clat_q == ACC_WORD) ? ACC_HI : ACC_NONE;
            else if (acc_q == ACC_WORD)
               rd_hi_q <= !rd_hi_q;
         end
      end
   end

   assert_acc_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc_q != ACC_NONE);
   assert_stat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      slat_q && stat_req && !data_re |=> $stable(slat_val_q));
   assert_cnt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clat_q != ACC_NONE) && cnt_req && !data_re |=> $stable(clat_val_q));
   assert_stat_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
      data_re && slat_q && !cnt_req |=> !slat_q && $stable(clat_q));
   assert_word_no_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      data_we && acc_q == ACC_WORD && !wr_hi_q |=> !ld_stb);
endmodule

// File: rtl/tmr_access_seq.sv
module tmr_access_seq
   import tmr_acc_pkg::*;
#(
   parameter int         NUM_CH  = 3,
   parameter logic [1:0] DEF_ACC = ACC_LO
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [1:0]               bus_addr,
   input  logic [BYTE_W-1:0]        bus_wdata,
   output logic [BYTE_W-1:0]        bus_rdata,
   input  logic [NUM_CH*WORD_W-1:0] cnt_in,
   input  logic [NUM_CH-1:0]        out_in,
   output logic [NUM_CH-1:0]        ld_stb,
   output logic [NUM_CH*WORD_W-1:0] ld_val
);
   generate
      if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_nch
         $error("NUM_CH must be 1..3");
      end
      if (DEF_ACC == ACC_NONE) begin : g_bad_acc
         $error("DEF_ACC must be a nonzero access code");
      end
   endgenerate

   logic [NUM_CH-1:0] cfg_we, cnt_req, stat_req, data_we, data_re;
   logic [BYTE_W-1:0] ch_rd [NUM_CH];

   tmr_ctl_decode #(.NUM_CH(NUM_CH)) u_dec (
      .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr), .wbits(bus_wdata[7:1]),
      .cfg_we(cfg_we), .cnt_req(cnt_req), .stat_req(stat_req),
      .data_we(data_we), .data_re(data_re)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         tmr_chan_port #(.DEF_ACC(DEF_ACC)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .cfg_we(cfg_we[c]), .cfg_bits(bus_wdata[5:0]),
            .cnt_req(cnt_req[c]), .stat_req(stat_req[c]),
            .data_we(data_we[c]), .data_re(data_re[c]),
            .wdata(bus_wdata),
            .cnt_live(cnt_in[c*WORD_W +: WORD_W]), .out_live(out_in[c]),
            .rdata(ch_rd[c]),
            .ld_stb(ld_stb[c]), .ld_val(ld_val[c*WORD_W +: WORD_W])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (data_re[i]) bus_rdata = ch_rd[i];
   end

   assert_ld_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_stb));
   assert_ld_after_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_stb != '0) |-> $past(bus_wr && bus_addr != 2'd3));
   assert_ctl_rd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd && !bus_wr && bus_addr == 2'd3 |-> bus_rdata == '0);
endmodule

// File: tb/tmr_access_seq_tb.sv
module tmr_access_seq_tb;
   localparam int CLK_PER = 10;

   logic        clk = 0, rst_n = 0;
   logic        bus_wr = 0, bus_rd = 0;
   logic [1:0]  bus_addr = 0;
   logic [7:0]  bus_wdata = 0, bus_rdata;
   logic [47:0] cnt_in = 0;
   logic [2:0]  out_in = 0;
   logic [2:0]  ld_stb;
   logic [47:0] ld_val;
   int n_chk = 0, n_fail = 0;
   logic [7:0] rv;

   tmr_access_seq u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cnt_in(cnt_in), .out_in(out_in), .ld_stb(ld_stb), .ld_val(ld_val)
   );

   always #(CLK_PER/2) clk = ~clk;

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      bus_rd = 1; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 0;
   endtask

   function automatic logic [2:0] fm(input logic [2:0] m);
      return (m > 5) ? m - 3'd4 : m;
   endfunction

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      cnt_in = {16'h5E6F, 16'h1234, 16'hA1B2};
      // R1: reset defaults, live low byte, no alternation, no strobe
      chk("R1", ld_stb, 0);
      rd(1, rv); chk("R1", rv, 8'h34);
      rd(1, rv); chk("R1", rv, 8'h34);
      wr(0, 8'h55); chk("R1", ld_stb, 3'b001); chk("R3", ld_val[15:0], 16'h0055);
      @(negedge clk); chk("R3", ld_stb, 0);
      // R11
      rd(3, rv); chk("R11", rv, 0);

      // R2, R7, R8: exhaustive control-word sweep through status read-back
      for (int c = 0; c < 3; c++)
         for (int a = 1; a < 4; a++)
            for (int m = 0; m < 8; m++)
               for (int b = 0; b < 2; b++) begin
                  out_in = 3'((m ^ b) & 1) << c;
                  wr(3, 8'((c << 6) | (a << 4) | (m << 1) | b));
                  wr(3, 8'(8'hE0 | (2 << c)));
                  rd(2'(c), rv);
                  chk("R8", rv, {out_in[c], 1'b0, 2'(a), fm(3'(m)), 1'(b)});
                  rd(2'(c), rv);
                  chk("R2", rv, (a == 2) ? cnt_in[c*16+8 +: 8] : cnt_in[c*16 +: 8]);
               end

      // R3: high-byte write on ch1
      wr(3, 8'h60);
      wr(1, 8'hC3); chk("R3", ld_stb, 3'b010); chk("R3", ld_val[31:16], 16'hC300);
      // R4: word write on ch2
      wr(3, 8'hB4);
      wr(2, 8'h11); chk("R4", ld_stb, 0);
      wr(2, 8'h22); chk("R4", ld_stb, 3'b100); chk("R4", ld_val[47:32], 16'h2211);
      wr(2, 8'h33); chk("R4", ld_stb, 0);
      wr(3, 8'hB4);                       // pointer reset mid-word (R2)
      wr(2, 8'h44); chk("R2", ld_stb, 0);
      wr(2, 8'h55); chk("R2", ld_val[47:32], 16'h5544);

      // R6: live word reads alternate low/high
      rd(2, rv); chk("R6", rv, 8'h6F);
      rd(2, rv); chk("R6", rv, 8'h5E);
      rd(2, rv); chk("R6", rv, 8'h6F);
      wr(3, 8'hB4);                       // pointer back to low
      rd(2, rv); chk("R6", rv, 8'h6F);
      wr(3, 8'hB4);

      // R5 + R9: capture word count, change live, second capture ignored
      wr(3, 8'h80);
      cnt_in[47:32] = 16'h7788;
      wr(3, 8'h80);
      rd(2, rv); chk("R5", rv, 8'h6F);
      rd(2, rv); chk("R9", rv, 8'h5E);
      rd(2, rv); chk("R5", rv, 8'h88);  // back to live, low byte

      // R5: capture in high-only mode on ch1
      wr(1, 8'h00);                       // ch1 in mode 2 from above
      wr(3, 8'h40);
      cnt_in[31:16] = 16'h9999;
      rd(1, rv); chk("R5", rv, 8'h12);
      rd(1, rv); chk("R5", rv, 8'h99);

      // R10 + R7: read-back of count+status on ch0 only
      wr(3, 8'h34);                       // ch0 word, mode 2
      out_in = 3'b001;
      cnt_in[15:0] = 16'hCAFE;
      wr(3, 8'hC2);
      cnt_in = {16'h0102, 16'h0304, 16'h0506};
      wr(3, 8'hC2);                       // R9: both ignored
      rd(1, rv); chk("R7", rv, 8'h03);    // ch1 unaffected, live high
      rd(0, rv); chk("R10", rv, 8'hB4);
      rd(0, rv); chk("R10", rv, 8'hFE);
      rd(0, rv); chk("R10", rv, 8'hCA);
      rd(0, rv); chk("R10", rv, 8'h06);
      rd(0, rv); chk("R10", rv, 8'h05);

      finish_run();
   end
endmodule